// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block decides which external interrupt level, if any, is posted to the processor core. Fifteen level lines from outside the core are merged with a software interrupt register. The merged set is compared against the processor interrupt level (PIL), and the highest pending level above the PIL becomes a trap-type index with a hard-interrupt request flag. The software register holds 17 bits. It can be changed by three strobed operations: set bits, clear bits, or load a whole value. Its two timer bits do not stand for levels of their own. Either of them raises level 14.

Several conditions gate the arbitration. A pending vectored interrupt outranks every external level, so it freezes the arbiter's outputs. If an external-interrupt trap of higher priority is already being handled at the current trap level, a new lower level is held back. If nothing pending lies above the PIL, or interrupts are globally disabled, any outstanding request is withdrawn. Each decision is registered, so the outputs follow the inputs one clock later.

Top module: `irq_level_arbiter`

## Requirements
- R1: The pending set is the external lines ORed with software register bits 1..15, each bit n standing for level n. External bit 0 and software bit 0 never select a level on their own.
- R2: When software register bit 0 or bit 16 is set, level 14 is pending.
- R3: While `vec_pend` is high, `irq_req` and `irq_tt` keep their values whatever the other inputs do.
- R4: With `vec_pend` low, if the pending set read as a number is below 2 shifted left by `pil`, then one cycle later `irq_req` is 0 and `irq_tt` is 0.
- R5: With `vec_pend` low, `int_en` high and no suppression, the highest pending level L with L > `pil` appears one cycle later as `irq_tt` = 0x40 + L with `irq_req` = 1. This also applies when a request is already outstanding and the winner changes.
- R6: The new level is not posted, and both outputs keep their values, when `trap_lvl` is nonzero, `saved_tt` bits 8:4 equal 4 (an external-interrupt code), and `saved_tt` is numerically greater than 0x40 + L.
- R7: With `vec_pend` low and `int_en` low, one cycle later `irq_req` is 0 and `irq_tt` is 0.
- R8: The software register is visible on `soft_q` one cycle after a strobe. `sw_wr` loads `sw_data`, `sw_clr` clears the bits set in `sw_data`, and `sw_set` sets them. When strobes coincide, write wins over clear and clear wins over set. A strobe that leaves the value unchanged has no effect on the outputs.
- R9: While `rst_n` is low, `soft_q`, `irq_tt` and `irq_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_lvl | input | 16 | External level lines, bit n = level n (bit 0 selects nothing) |
| pil | input | 4 | Processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| vec_pend | input | 1 | Vectored interrupt pending, freezes arbitration |
| trap_lvl | input | 3 | Current trap level |
| saved_tt | input | 9 | Trap type saved at the current trap level |
| sw_set | input | 1 | Strobe: OR `sw_data` into the software register |
| sw_clr | input | 1 | Strobe: clear the bits of `sw_data` in the software register |
| sw_wr | input | 1 | Strobe: load `sw_data` into the software register |
| sw_data | input | 17 | Operand for the software register strobes |
| soft_q | output | 17 | Software interrupt register contents |
| irq_tt | output | 9 | Posted trap type (0x41..0x4F), zero when idle |
| irq_req | output | 1 | Hard-interrupt request to the core |

## Verification
The hardest case to reach is suppression. To observe it, `trap_lvl` and `saved_tt` must describe a higher external trap already in service while a fresh lower level would otherwise win. The result must also be distinguished from "nothing happened". The bench first lets a low level post, so the outputs hold a known nonzero value. It then raises a higher level while sweeping `saved_tt` across the boundary codes around the new trap type, and across non-external codes. For each point it checks whether the outputs hold or retarget. The freeze under `vec_pend` is reached the same way: a request is established first, then every other input is disturbed while the flag is held high.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_N     = 16;
  localparam int SOFT_W    = 17;
  localparam int TT_W      = 9;
  localparam int PIL_W     = $clog2(LVL_N);
  localparam int TIMER_LO  = 0;
  localparam int TIMER_HI  = 16;
  localparam int TIMER_LVL = 14;
  localparam int CLASS_LSB = PIL_W;

  typedef logic [LVL_N-1:0]  lvl_vec_t;
  typedef logic [SOFT_W-1:0] soft_t;
  typedef logic [TT_W-1:0]   tt_t;
  typedef logic [PIL_W-1:0]  pil_t;

  localparam tt_t EXT_BASE = tt_t'(9'h040);

  typedef enum logic [1:0] {SW_HOLD, SW_SET, SW_CLR, SW_WR} sw_op_e;

  function automatic soft_t soft_apply(sw_op_e op, soft_t cur, soft_t v);
    case (op)
      SW_WR:   return v;
      SW_CLR:  return cur & ~v;
      SW_SET:  return cur | v;
      default: return cur;
    endcase
  endfunction

  function automatic lvl_vec_t merge_pend(lvl_vec_t ext, soft_t s);
    lvl_vec_t p;
    p = ext | (s[LVL_N-1:0] & ~lvl_vec_t'(1));
    if (s[TIMER_LO] || s[TIMER_HI]) p[TIMER_LVL] = 1'b1;
    return p;
  endfunction

  function automatic logic under_limit(lvl_vec_t p, pil_t pil);
    logic [LVL_N:0] lim;
    lim = (LVL_N+1)'(2) << pil;
    return {1'b0, p} < lim;
  endfunction

  function automatic pil_t top_level(lvl_vec_t p, pil_t pil);
    pil_t lvl;
    logic found;
    lvl = '0;
    found = 1'b0;
    for (int i = LVL_N-1; i > 0; i--) begin
      if (!found && p[i] && (i > int'(pil))) begin
        lvl = pil_t'(i);
        found = 1'b1;
      end
    end
    return lvl;
  endfunction

  function automatic tt_t level_tt(pil_t l);
    return EXT_BASE | tt_t'(l);
  endfunction

  function automatic logic outranked(tt_t saved, tt_t cand);
    return (saved[TT_W-1:CLASS_LSB] == EXT_BASE[TT_W-1:CLASS_LSB]) && (saved > cand);
  endfunction
endpackage

// File: rtl/irq_soft_reg.sv
module irq_soft_reg
  import irq_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_i,
  input  logic  clr_i,
  input  logic  wr_i,
  input  soft_t data_i,
  output soft_t q_o
);
  sw_op_e op;
  soft_t  nxt;

  always_comb begin
    if (wr_i)       op = SW_WR;
    else if (clr_i) op = SW_CLR;
    else if (set_i) op = SW_SET;
    else            op = SW_HOLD;
    nxt = soft_apply(op, q_o, data_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          q_o <= '0;
    else if (nxt != q_o) q_o <= nxt;
  end
endmodule

// File: rtl/irq_pend_merge.sv
module irq_pend_merge
  import irq_arb_pkg::*;
(
  input  lvl_vec_t ext_i,
  input  soft_t    soft_i,
  output lvl_vec_t pend_o
);
  assign pend_o = merge_pend(ext_i, soft_i);
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_arb_pkg::*;
(
  input  lvl_vec_t pend_i,
  input  pil_t     pil_i,
  output logic     below_o,
  output tt_t      tt_o
);
  assign below_o = under_limit(pend_i, pil_i);
  assign tt_o    = level_tt(top_level(pend_i, pil_i));
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int TL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_N-1:0]  ext_lvl,
  input  logic [PIL_W-1:0]  pil,
  input  logic              int_en,
  input  logic              vec_pend,
  input  logic [TL_W-1:0]   trap_lvl,
  input  logic [TT_W-1:0]   saved_tt,
  input  logic              sw_set,
  input  logic              sw_clr,
  input  logic              sw_wr,
  input  logic [SOFT_W-1:0] sw_data,
  output logic [SOFT_W-1:0] soft_q,
  output logic [TT_W-1:0]   irq_tt,
  output logic              irq_req
);
  lvl_vec_t pend_w;
  logic     below_thr_w;
  tt_t      win_tt_w;
  logic     suppress_w;
  logic     post_w;
  logic     drop_w;

  irq_soft_reg u_soft (
    .clk(clk), .rst_n(rst_n), .set_i(sw_set), .clr_i(sw_clr),
    .wr_i(sw_wr), .data_i(sw_data), .q_o(soft_q)
  );

  irq_pend_merge u_merge (
    .ext_i(ext_lvl), .soft_i(soft_q), .pend_o(pend_w)
  );

  irq_level_pick u_pick (
    .pend_i(pend_w), .pil_i(pil), .below_o(below_thr_w), .tt_o(win_tt_w)
  );

  assign suppress_w = (trap_lvl != '0) && outranked(saved_tt, win_tt_w);
  assign drop_w     = !vec_pend && (below_thr_w || !int_en);
  assign post_w     = !vec_pend && !below_thr_w && int_en && !suppress_w
                      && (win_tt_w != irq_tt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_tt  <= '0;
    end else if (drop_w) begin
      irq_req <= 1'b0;
      irq_tt  <= '0;
    end else if (post_w) begin
      irq_req <= 1'b1;
      irq_tt  <= win_tt_w;
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        int_en,
  input logic        vec_pend,
  input logic        sw_wr,
  input soft_t       sw_data,
  input pil_t        pil,
  input logic        below_thr_w,
  input soft_t       soft_q,
  input tt_t         irq_tt,
  input logic        irq_req
);
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vec_pend |=> ($stable(irq_req) && $stable(irq_tt))); // R3

  AST_BELOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_pend && below_thr_w) |=> (!irq_req && irq_tt == '0)); // R4

  AST_RAISE_ABOVE_PIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (irq_tt[CLASS_LSB-1:0] > $past(pil))); // R5

  AST_TT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_tt[TT_W-1:CLASS_LSB] == EXT_BASE[TT_W-1:CLASS_LSB]
                 && irq_tt[CLASS_LSB-1:0] != '0)); // R5

  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_pend && !int_en) |=> (!irq_req && irq_tt == '0)); // R7

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (soft_q == $past(sw_data))); // R8
endmodule

bind irq_level_arbiter irq_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_en(int_en), .vec_pend(vec_pend),
  .sw_wr(sw_wr), .sw_data(sw_data), .pil(pil), .below_thr_w(below_thr_w),
  .soft_q(soft_q), .irq_tt(irq_tt), .irq_req(irq_req)
);

// File: tb/sim_irq_level_arbiter.sv
`timescale 1ns/1ps
module sim_irq_level_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ext_lvl;
  logic [3:0]  pil;
  logic        int_en, vec_pend;
  logic [2:0]  trap_lvl;
  logic [8:0]  saved_tt;
  logic        sw_set, sw_clr, sw_wr;
  logic [16:0] sw_data;
  logic [16:0] soft_q;
  logic [8:0]  irq_tt;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [16:0] m_soft;
  logic [8:0]  m_tt;
  logic        m_req;

  always #2 clk = ~clk;

  irq_level_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .pil(pil), .int_en(int_en),
    .vec_pend(vec_pend), .trap_lvl(trap_lvl), .saved_tt(saved_tt),
    .sw_set(sw_set), .sw_clr(sw_clr), .sw_wr(sw_wr), .sw_data(sw_data),
    .soft_q(soft_q), .irq_tt(irq_tt), .irq_req(irq_req)
  );

  task automatic model_edge();
    int p, win, cand;
    if (!rst_n) begin
      m_soft = '0; m_tt = '0; m_req = 1'b0;
      return;
    end
    p = int'(ext_lvl);
    for (int b = 1; b < 16; b++) if (m_soft[b]) p = p | (1 << b);
    if (m_soft[0] || m_soft[16]) p = p | (1 << 14);
    win = 0;
    for (int l = 1; l < 16; l++) if (l > int'(pil) && ((p >> l) & 1) == 1) win = l;
    cand = 64 + win;
    if (!vec_pend) begin
      if (p < (2 << pil) || !int_en) begin
        m_req = 1'b0; m_tt = '0;
      end else if (!(trap_lvl != 0 && (int'(saved_tt) / 16) == 4 && int'(saved_tt) > cand)) begin
        if (int'(m_tt) != cand) begin
          m_tt = 9'(cand); m_req = 1'b1;
        end
      end
    end
    if (sw_wr)       m_soft = sw_data;
    else if (sw_clr) m_soft = m_soft & ~sw_data;
    else if (sw_set) m_soft = m_soft | sw_data;
  endtask

  task automatic check(string tag);
    checks++;
    if (irq_req !== m_req || irq_tt !== m_tt || soft_q !== m_soft) begin
      errors++;
      $display("FAIL %s req=%0b tt=%h soft=%h expected req=%0b tt=%h soft=%h",
               tag, irq_req, irq_tt, soft_q, m_req, m_tt, m_soft);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
    sw_set = 0; sw_clr = 0; sw_wr = 0;
  endtask

  task automatic idle_clear();
    ext_lvl = '0; vec_pend = 0; int_en = 1;
    cyc("R4");
  endtask

  initial begin
    rst_n = 0; ext_lvl = '0; pil = '0; int_en = 1; vec_pend = 0;
    trap_lvl = '0; saved_tt = '0; sw_set = 0; sw_clr = 0; sw_wr = 0; sw_data = '0;
    ext_lvl = 16'h8000; sw_wr = 1; sw_data = 17'h1ffff;
    repeat (3) cyc("R9");
    rst_n = 1; sw_wr = 0; ext_lvl = '0;
    cyc("R9");

    // R5 / R4: every pil against every single external level
    for (int pv = 0; pv < 16; pv++) begin
      for (int l = 1; l < 16; l++) begin
        idle_clear();
        pil = 4'(pv); ext_lvl = 16'(1 << l);
        cyc(l > pv ? "R5" : "R4");
      end
    end

    // R5: every pair of levels at pil 0, plus retarget while asserted
    pil = 0;
    for (int a = 1; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        idle_clear();
        ext_lvl = 16'(1 << a);
        cyc("R5");
        ext_lvl = 16'((1 << a) | (1 << b));
        cyc("R5");
        ext_lvl = 16'(1 << a);
        cyc("R5");
      end
    end

    // R1: bit 0 of ext never selects; each software bit maps to its level
    idle_clear();
    ext_lvl = 16'h0001;
    cyc("R1"); cyc("R1");
    ext_lvl = '0;
    for (int b = 1; b < 16; b++) begin
      sw_wr = 1; sw_data = 17'(1 << b);
      cyc("R1"); cyc("R1");
    end

    // R2: timer bits raise level 14
    sw_wr = 1; sw_data = 17'h00001; cyc("R2"); cyc("R2");
    sw_wr = 1; sw_data = 17'h10000; cyc("R2"); cyc("R2");
    pil = 14; cyc("R2");
    pil = 13; cyc("R2");
    pil = 0;

    // R8: set / clear / write and priority
    sw_wr = 1; sw_data = 17'h12345; cyc("R8");
    sw_set = 1; sw_data = 17'h000f0; cyc("R8");
    sw_clr = 1; sw_data = 17'h10305; cyc("R8");
    sw_set = 1; sw_clr = 1; sw_data = 17'h00040; cyc("R8");
    sw_wr = 1; sw_clr = 1; sw_set = 1; sw_data = 17'h00a00; cyc("R8");
    cyc("R8");
    sw_set = 1; sw_data = 17'h00800; cyc("R8");
    sw_wr = 1; sw_data = 17'h00a00; cyc("R8");
    sw_wr = 1; sw_data = '0; cyc("R8"); cyc("R8");

    // R3: freeze under vectored interrupt
    idle_clear();
    ext_lvl = 16'h0020; cyc("R3");
    vec_pend = 1;
    ext_lvl = 16'h0200; cyc("R3");
    int_en = 0; cyc("R3");
    ext_lvl = '0; cyc("R3");
    pil = 15; sw_wr = 1; sw_data = 17'h08000; cyc("R3"); cyc("R3");
    vec_pend = 0; int_en = 1; pil = 0; ext_lvl = 16'h0200; cyc("R3");
    sw_wr = 1; sw_data = '0; cyc("R3");

    // R6: suppression sweep over saved trap types and trap levels
    for (int tl = 0; tl < 2; tl++) begin
      for (int s = 0; s < 22; s++) begin
        logic [8:0] code;
        code = (s < 18) ? 9'(9'h03f + s) : (s == 18 ? 9'h14f : (s == 19 ? 9'h1c9 : (s == 20 ? 9'h0ff : 9'h000)));
        idle_clear();
        trap_lvl = 3'(tl); saved_tt = '0;
        ext_lvl = 16'h0008; cyc("R6");
        saved_tt = code;
        ext_lvl = 16'h0048; cyc("R6");
        ext_lvl = 16'h0008; cyc("R6");
        saved_tt = '0; trap_lvl = '0;
      end
    end

    // R7: global disable drops an outstanding request
    idle_clear();
    ext_lvl = 16'h1000; cyc("R7");
    int_en = 0; cyc("R7"); cyc("R7");
    int_en = 1; cyc("R7");

    // R9: reset in the middle of activity
    sw_wr = 1; sw_data = 17'h00400; cyc("R9");
    rst_n = 0; cyc("R9");
    rst_n = 1; ext_lvl = '0; cyc("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule